// File: doc/BRIEF.md
# Serial Payload Output Port

This block turns a stream of decoded payload bytes into a synchronous serial stream. It makes its own bit clock by dividing the system clock under register control. Beside clock and data it drives three framing strobes: a packet strobe that marks the first byte of each 448-byte burst, a byte strobe that marks the first bit of every byte, and one shared line. That shared line carries either a frame-sync pulse or a per-byte error flag.

Bytes arrive on a valid/ready handshake together with a packet-start marker and an error flag. A byte is taken only at a bit-period boundary, so the stream has no gaps while the source keeps up. Three configuration inputs (clock, data format, sync) set the divider, clock polarity, clock gating, bit order, parity and the use of the shared line. They are copied into working registers only at burst boundaries, so a burst is never sent with mixed settings. A frame tick input, pulsed once per frame by the surrounding logic, is the source of the frame-sync pulse.

Top module: `payload_serial_tx`

## Requirements
- R1: A byte is accepted on a clock edge where `inValid` and `inReady` are both high. `inReady` is high only in the last system cycle of a bit period, and only when the port is idle or that period holds the last bit of the current byte.
- R2: One serial bit period lasts 2*(`clkCfg[6:2]`+1) system clock cycles, so the value 0 gives the fastest rate and 31 the slowest.
- R3: With `clkCfg[1]`=0, `serClk` is low in the first half of every bit period, and its rising edge is the active edge. With `clkCfg[1]`=1 the levels are inverted and the falling edge is active.
- R4: With `clkCfg[0]`=1, `serClk` is held at 1 while no byte is being sent. With `clkCfg[0]`=0 it toggles at the bit rate at all times.
- R5: With `fmtCfg[0]`=1 the byte is sent most significant bit first. With `fmtCfg[0]`=0 it is sent least significant bit first.
- R6: With `fmtCfg[1]`=1 a ninth bit follows the eight data bits. This bit makes the count of ones in all nine bits even when `fmtCfg[2]`=0 and odd when `fmtCfg[2]`=1. With `fmtCfg[1]`=0 a byte is eight bits.
- R7: `byteSync` is high for exactly the first bit period of every byte and low otherwise.
- R8: `pktSync` is high for exactly the first bit period of the first byte of a burst. A burst is 448 bytes, and a byte sent with `inPktStart`=1 starts a new burst.
- R9: With `syncCfg`=0, `frameErr` goes high for exactly one bit period. That period starts at the first bit-period boundary at or after a `frameTick` pulse.
- R10: With `syncCfg`=1, `frameErr` equals the `errFlag` that was given with the byte, for every bit of that byte, and it is low while idle.
- R11: `serData` changes only at the start of a bit period (the inactive edge), so it is stable across the active edge. It is 0 while idle.
- R12: The configuration inputs are copied when a byte that starts a burst is accepted, or at an idle bit-period boundary when no burst is under way. Changes made during a burst have no effect on the rest of that burst.
- R13: During reset `serClk`, `serData`, `pktSync`, `byteSync`, `frameErr` and `inReady` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Payload byte |
| inValid | input | 1 | Payload byte is offered |
| inReady | output | 1 | Port takes the byte on this edge |
| inPktStart | input | 1 | Offered byte begins a new burst |
| errFlag | input | 1 | Error flag belonging to the offered byte |
| frameTick | input | 1 | One-cycle pulse once per frame |
| clkCfg | input | 7 | [6:2] divider, [1] polarity, [0] park high when idle |
| fmtCfg | input | 3 | [0] MSB first, [1] parity on, [2] odd parity |
| syncCfg | input | 1 | 0 frame sync, 1 error flag on the shared line |
| serClk | output | 1 | Serial bit clock |
| serData | output | 1 | Serial data |
| pktSync | output | 1 | Burst start strobe |
| byteSync | output | 1 | Byte start strobe |
| frameErr | output | 1 | Frame sync or error flag |

## Verification
A byte accepted at a boundary edge puts its first bit, `byteSync` and `pktSync` on the outputs in the very next system cycle. Each bit then holds for 2*(divider+1) cycles, and `inReady` rises in the cycle just before the edge that takes the next byte. The frame pulse appears one cycle after the first boundary edge that sees the tick. The bench samples at falling system-clock edges and finds the active serial edges from the `serClk` level and the expected polarity, so bits and strobes are compared at the active edge and never at a guessed cycle count. Waits after each byte cover at least three more bit periods than the byte needs, and the handshake-window check counts exactly 64 samples, worked out for a divider of 3.

// File: rtl/pstx_pkg.sv
package pstx_pkg;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 5;
  localparam int BIT_W  = $clog2(BYTE_W + 1);

  // clock configuration, packed as the register: [6:2] divider, [1] polarity, [0] park
  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             pol;
    logic             park;
  } clk_cfg_t;

  // format configuration: [2] odd parity, [1] parity on, [0] msb first
  typedef struct packed {
    logic oddPar;
    logic parEn;
    logic msbFirst;
  } fmt_cfg_t;

  // strobes and state handed from control to datapath
  typedef struct packed {
    logic             load;
    logic             busy;
    logic             pktByte;
    logic             frameOut;
    logic [BIT_W-1:0] bitIdx;
  } seq_t;
endpackage

// File: rtl/pstx_ctrl.sv
module pstx_ctrl
  import pstx_pkg::*;
#(
  parameter int BURST_LEN = 448
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inPktStart,
  input  logic             frameTick,
  input  logic [DIV_W+1:0] clkCfgIn,
  input  logic [2:0]       fmtCfgIn,
  input  logic             syncSelIn,
  output logic             inReady,
  output seq_t             seq,
  output fmt_cfg_t         actFmt,
  output logic             actSel,
  output logic             actPol,
  output logic             actPark,
  output logic             ckPh
);
  localparam int CNT_W = $clog2(BURST_LEN + 1);

  clk_cfg_t         actClk;
  logic [DIV_W-1:0] halfCnt;
  logic             busyQ;
  logic [BIT_W-1:0] bitIdx;
  logic [CNT_W-1:0] byteIdx;
  logic             pktByte;
  logic             framePend;
  logic             frameOut;

  logic             boundary;
  logic             endOfByte;
  logic             take;
  logic             burstStart;
  logic             cfgLoad;
  logic [BIT_W-1:0] lastBit;
  logic [CNT_W-1:0] baseIdx;
  logic [CNT_W-1:0] nextIdx;

  always_comb begin
    boundary   = ckPh && (halfCnt == actClk.div);
    lastBit    = actFmt.parEn ? BIT_W'(BYTE_W) : BIT_W'(BYTE_W - 1);
    endOfByte  = !busyQ || (bitIdx == lastBit);
    inReady    = boundary && endOfByte;
    take       = inReady && inValid;
    burstStart = inPktStart || (byteIdx == '0);
    cfgLoad    = (take && burstStart) ||
                 (boundary && endOfByte && !inValid && (byteIdx == '0));
    baseIdx    = burstStart ? '0 : byteIdx;
    nextIdx    = baseIdx + CNT_W'(1);
    if (nextIdx == CNT_W'(BURST_LEN)) nextIdx = '0;
  end

  // half-period divider and phase
  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfCnt <= '0;
      ckPh    <= 1'b0;
    end else if (halfCnt == actClk.div) begin
      halfCnt <= '0;
      ckPh    <= ~ckPh;
    end else begin
      halfCnt <= halfCnt + DIV_W'(1);
    end
  end

  // byte sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      bitIdx  <= '0;
      byteIdx <= '0;
      pktByte <= 1'b0;
    end else if (boundary) begin
      if (take) begin
        busyQ   <= 1'b1;
        bitIdx  <= '0;
        pktByte <= burstStart;
        byteIdx <= nextIdx;
      end else if (endOfByte) begin
        busyQ   <= 1'b0;
        bitIdx  <= '0;
        pktByte <= 1'b0;
      end else begin
        bitIdx  <= bitIdx + BIT_W'(1);
      end
    end
  end

  // frame pulse, aligned to bit periods
  always_ff @(posedge clk) begin
    if (!rstN) begin
      framePend <= 1'b0;
      frameOut  <= 1'b0;
    end else if (boundary) begin
      frameOut  <= framePend || frameTick;
      framePend <= 1'b0;
    end else begin
      framePend <= framePend || frameTick;
    end
  end

  // working configuration, refreshed only at burst boundaries
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actClk <= '0;
      actFmt <= '0;
      actSel <= 1'b0;
    end else if (cfgLoad) begin
      actClk <= clk_cfg_t'(clkCfgIn);
      actFmt <= fmt_cfg_t'(fmtCfgIn);
      actSel <= syncSelIn;
    end
  end

  always_comb begin
    actPol       = actClk.pol;
    actPark      = actClk.park;
    seq.load     = take;
    seq.busy     = busyQ;
    seq.pktByte  = pktByte;
    seq.frameOut = frameOut;
    seq.bitIdx   = bitIdx;
  end
endmodule

// File: rtl/pstx_dp.sv
module pstx_dp
  import pstx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seq_t              seq,
  input  fmt_cfg_t          actFmt,
  input  logic              actSel,
  input  logic              actPol,
  input  logic              actPark,
  input  logic              ckPh,
  input  logic [BYTE_W-1:0] inData,
  input  logic              errFlag,
  output logic              serClk,
  output logic              serData,
  output logic              pktSync,
  output logic              byteSync,
  output logic              frameErr
);
  logic [BYTE_W-1:0] byteReg;
  logic              errReg;
  logic              dataBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteReg <= '0;
      errReg  <= 1'b0;
    end else if (seq.load) begin
      byteReg <= inData;
      errReg  <= errFlag;
    end
  end

  // pick the current bit; the index past the data bits is the parity slot
  always_comb begin
    dataBit = (^byteReg) ^ actFmt.oddPar;
    for (int i = 0; i < BYTE_W; i++) begin
      if (seq.bitIdx == BIT_W'(i))
        dataBit = actFmt.msbFirst ? byteReg[BYTE_W-1-i] : byteReg[i];
    end
  end

  always_comb begin
    serData  = seq.busy && dataBit;
    serClk   = (actPark && !seq.busy) ? 1'b1 : (ckPh ^ actPol);
    byteSync = seq.busy && (seq.bitIdx == '0);
    pktSync  = byteSync && seq.pktByte;
    frameErr = actSel ? (seq.busy && errReg) : seq.frameOut;
  end
endmodule

// File: rtl/payload_serial_tx.sv
module payload_serial_tx
  import pstx_pkg::*;
#(
  parameter int BURST_LEN = 448
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic              inPktStart,
  input  logic              errFlag,
  input  logic              frameTick,
  input  logic [DIV_W+1:0]  clkCfg,
  input  logic [2:0]        fmtCfg,
  input  logic              syncCfg,
  output logic              serClk,
  output logic              serData,
  output logic              pktSync,
  output logic              byteSync,
  output logic              frameErr
);
  seq_t     seq;
  fmt_cfg_t actFmt;
  logic     actSel;
  logic     actPol;
  logic     actPark;
  logic     ckPh;
  logic     busy;

  assign busy = seq.busy;

  pstx_ctrl #(.BURST_LEN(BURST_LEN)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inPktStart (inPktStart),
    .frameTick  (frameTick),
    .clkCfgIn   (clkCfg),
    .fmtCfgIn   (fmtCfg),
    .syncSelIn  (syncCfg),
    .inReady    (inReady),
    .seq        (seq),
    .actFmt     (actFmt),
    .actSel     (actSel),
    .actPol     (actPol),
    .actPark    (actPark),
    .ckPh       (ckPh)
  );

  pstx_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .seq      (seq),
    .actFmt   (actFmt),
    .actSel   (actSel),
    .actPol   (actPol),
    .actPark  (actPark),
    .ckPh     (ckPh),
    .inData   (inData),
    .errFlag  (errFlag),
    .serClk   (serClk),
    .serData  (serData),
    .pktSync  (pktSync),
    .byteSync (byteSync),
    .frameErr (frameErr)
  );
endmodule

// File: rtl/pstx_checker.sv
module pstx_checker (
  input logic clk,
  input logic rstN,
  input logic serData,
  input logic byteSync,
  input logic pktSync,
  input logic frameErr,
  input logic inReady,
  input logic busy,
  input logic ckPh,
  input logic actSel
);
  AST_DATA_HELD_SECOND_HALF: assert property (@(posedge clk) disable iff (!rstN)
    ckPh |-> $stable(serData)); // R11

  AST_DATA_LOW_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !serData); // R11

  AST_PKT_WITHIN_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    pktSync |-> byteSync); // R8

  AST_READY_LATE_HALF: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> ckPh); // R1

  AST_BYTE_SYNC_PERIOD_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(byteSync) |-> !ckPh); // R7

  AST_ERR_LINE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (actSel && !busy) |-> !frameErr); // R10
endmodule

bind payload_serial_tx pstx_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .serData  (serData),
  .byteSync (byteSync),
  .pktSync  (pktSync),
  .frameErr (frameErr),
  .inReady  (inReady),
  .busy     (busy),
  .ckPh     (ckPh),
  .actSel   (actSel)
);

// File: tb/payload_serial_tx_bench.sv
module payload_serial_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {div[4:0], pol, park, msb, parEn, odd, sel, err, data[7:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    {5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
    {5'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C},
    {5'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hB7},
    {5'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h81},
    {5'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFE},
    {5'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h6D},
    {5'd4, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    {5'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic       inPktStart = 1'b0;
  logic       errFlag = 1'b0;
  logic       frameTick = 1'b0;
  logic [6:0] clkCfg = '0;
  logic [2:0] fmtCfg = '0;
  logic       syncCfg = 1'b0;
  logic       serClk, serData, pktSync, byteSync, frameErr;

  int nChk = 0;
  int nFail = 0;

  // capture state
  int   cyc = 0;
  logic expPol = 1'b0;
  logic armed = 1'b0;
  logic started = 1'b0;
  logic gotStart = 1'b0;
  logic clkAtStart = 1'b0;
  logic prevClk = 1'b0;
  logic prevBs = 1'b0;
  int   nEdge = 0;
  int   bsCount = 0;
  int   psCount = 0;
  int   psAtByte = 0;
  logic capData [64];
  logic capBs [64];
  logic capPs [64];
  logic capFe [64];
  int   capCyc [64];

  always #(CLK_PERIOD / 2) clk = ~clk;

  payload_serial_tx u_payload_serial_tx (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inReady(inReady),
    .inPktStart(inPktStart), .errFlag(errFlag), .frameTick(frameTick),
    .clkCfg(clkCfg), .fmtCfg(fmtCfg), .syncCfg(syncCfg),
    .serClk(serClk), .serData(serData), .pktSync(pktSync),
    .byteSync(byteSync), .frameErr(frameErr)
  );

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (armed) begin
      if (!prevBs && byteSync && !gotStart) begin
        clkAtStart = serClk;
        gotStart = 1'b1;
      end
      if (prevClk == expPol && serClk != expPol) begin
        if (byteSync) begin
          bsCount = bsCount + 1;
          started = 1'b1;
        end
        if (pktSync) begin
          psCount = psCount + 1;
          psAtByte = bsCount;
        end
        if (started && nEdge < 64) begin
          capData[nEdge] = serData;
          capBs[nEdge] = byteSync;
          capPs[nEdge] = pktSync;
          capFe[nEdge] = frameErr;
          capCyc[nEdge] = cyc;
          nEdge = nEdge + 1;
        end
      end
    end
    prevClk = serClk;
    prevBs = byteSync;
  end

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  task automatic setCfg(input logic [4:0] dv, input logic pol, input logic park,
                        input logic msb, input logic par, input logic odd, input logic sel);
    @(negedge clk);
    clkCfg = {dv, pol, park};
    fmtCfg = {odd, par, msb};
    syncCfg = sel;
    expPol = pol;
  endtask

  task automatic arm();
    @(posedge clk);
    armed = 1'b1;
    started = 1'b0;
    gotStart = 1'b0;
    nEdge = 0;
    bsCount = 0;
    psCount = 0;
    psAtByte = 0;
  endtask

  task automatic sendByte(input logic [7:0] d, input logic pkt, input logic err);
    @(negedge clk);
    inData = d;
    inValid = 1'b1;
    inPktStart = pkt;
    errFlag = err;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
    inPktStart = 1'b0;
    errFlag = 1'b0;
  endtask

  function automatic logic expBit(input logic [7:0] d, input int i,
                                  input logic msb, input logic odd);
    if (i == 8) return (^d) ^ odd;
    return msb ? d[7-i] : d[i];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    // R13: reset state
    repeat (3) @(negedge clk);
    check("R13 serClk", int'(serClk), 0);
    check("R13 serData", int'(serData), 0);
    check("R13 pktSync", int'(pktSync), 0);
    check("R13 byteSync", int'(byteSync), 0);
    check("R13 frameErr", int'(frameErr), 0);
    check("R13 inReady", int'(inReady), 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: R2 R3 R5 R6 R7 R8 R10
    for (int k = 0; k < NVEC; k++) begin
      logic [19:0] v;
      int f, nb, per;
      v = VEC[k];
      f = int'(v[19:15]);
      nb = v[11] ? 9 : 8;
      per = 2 * (f + 1);
      setCfg(v[19:15], v[14], v[13], v[12], v[11], v[10], v[9]);
      arm();
      sendByte(v[7:0], 1'b1, v[8]);
      repeat ((nb + 3) * per) @(negedge clk);
      check($sformatf("R3 v%0d clock level at byte start", k), int'(clkAtStart), int'(v[14]));
      check($sformatf("R2 v%0d edges seen", k), int'(nEdge >= nb), 1);
      check($sformatf("R2 v%0d bit period", k), capCyc[1] - capCyc[0], per);
      for (int i = 0; i < nb; i++) begin
        check($sformatf("R5 R6 v%0d bit %0d", k, i), int'(capData[i]),
              int'(expBit(v[7:0], i, v[12], v[10])));
        check($sformatf("R7 v%0d byteSync bit %0d", k, i), int'(capBs[i]), int'(i == 0));
        check($sformatf("R8 v%0d pktSync bit %0d", k, i), int'(capPs[i]), int'(i == 0));
        check($sformatf("R10 v%0d frameErr bit %0d", k, i), int'(capFe[i]),
              int'(v[9] && v[8]));
      end
      armed = 1'b0;
    end

    // R4 parked clock and R10 idle low (last vector: park on, error mode)
    begin
      int lows, highs;
      lows = 0;
      highs = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (!serClk) lows++;
        if (frameErr) highs++;
      end
      check("R4 parked clock low samples", lows, 0);
      check("R10 idle frameErr high samples", highs, 0);
    end

    // R4 free-running clock while idle
    begin
      int changes;
      logic prev;
      setCfg(5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      sendByte(8'h11, 1'b1, 1'b0);
      repeat (30) @(negedge clk);
      changes = 0;
      prev = serClk;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (serClk != prev) changes++;
        prev = serClk;
      end
      check("R4 idle clock toggles", changes, 30);
    end

    // R9 frame sync pulse one bit period wide
    begin
      int highs, rises;
      logic prev;
      setCfg(5'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      sendByte(8'h22, 1'b1, 1'b0);
      repeat (11 * 6) @(negedge clk);
      frameTick = 1'b1;
      @(negedge clk);
      frameTick = 1'b0;
      highs = 0;
      rises = 0;
      prev = 1'b0;
      for (int i = 0; i < 40; i++) begin
        if (frameErr) highs++;
        if (frameErr && !prev) rises++;
        prev = frameErr;
        @(negedge clk);
      end
      check("R9 frame pulse cycles", highs, 6);
      check("R9 frame pulse count", rises, 1);
    end

    // R1 ready only at the end of the last bit while busy
    begin
      int early;
      setCfg(5'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      sendByte(8'h5C, 1'b1, 1'b0);
      early = 0;
      for (int i = 0; i < 63; i++) begin
        if (inReady) early++;
        @(negedge clk);
      end
      check("R1 ready during byte", early, 0);
      check("R1 ready at last bit end", int'(inReady), 1);
      repeat (20) @(negedge clk);
    end

    // R12 configuration change mid-burst is ignored
    begin
      setCfg(5'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      arm();
      sendByte(8'h5A, 1'b1, 1'b0);
      setCfg(5'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      sendByte(8'hC3, 1'b0, 1'b0);
      repeat (80) @(negedge clk);
      check("R12 second byte period", capCyc[9] - capCyc[8], 4);
      check("R12 second byte sync", int'(capBs[8]), 1);
      check("R12 second byte no packet sync", int'(capPs[8]), 0);
      for (int i = 0; i < 8; i++)
        check($sformatf("R12 second byte bit %0d", i), int'(capData[8 + i]),
              int'(expBit(8'hC3, i, 1'b1, 1'b0)));
      check("R12 no parity bit, next edge idle", int'(capBs[16]), 0);
      armed = 1'b0;
    end

    // R8 burst of 448 bytes then a new burst
    begin
      setCfg(5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      arm();
      for (int b = 0; b < 449; b++)
        sendByte(8'(b), b == 0, 1'b0);
      repeat (40) @(negedge clk);
      check("R7 byte strobes in 449 bytes", bsCount, 449);
      check("R8 packet strobes in 449 bytes", psCount, 2);
      check("R8 second packet strobe on byte 449", psAtByte, 449);
      armed = 1'b0;
    end

    summary();
    $finish;
  end
endmodule